// File: doc/BRIEF.md
# Block Address Translation Array

This block translates a 32-bit effective address into a 32-bit physical address using a small array of software-loaded block descriptors. Each descriptor covers a naturally aligned block whose size is a power of two, from 128 KB up to 256 MB. Every lookup compares the address against all descriptors in the same cycle. The block returns a hit flag, the physical address, the protection code and the index of the winning descriptor.

The block also takes the result of the page TLB that runs in parallel. When a descriptor matches, its translation is used and the page result is ignored. When no descriptor matches, the page TLB's hit and address pass through. Software loads each descriptor through a word-wide write port, one word per write. Each descriptor has a compare word and a translate word.

The lookup result is registered. It appears on the outputs one clock after the request strobe.

Top module: `bat_xlate`

## Requirements
- R1: The array holds N_ENT (default 4) descriptors. A write with `wr_en` high stores `wr_data` into descriptor `wr_idx`. With `wr_hi`=1 it loads the compare word; with `wr_hi`=0 it loads the translate word. Compare word layout: effective base in bits 31:17, size mask in bits 12:2, supervisor-valid in bit 1, user-valid in bit 0. Translate word layout: physical base in bits 31:17, protection code in bits 1:0. All other bits are ignored. Writing one word leaves the other word and all other descriptors unchanged.
- R2: A lookup compares the address with every descriptor in parallel. Address bits 31:28 must always equal the base. Address bits 27:17 must equal the base wherever the mask bit is 0.
- R3: Mask bit i (compare-word bit 2+i) excludes address bit 17+i from the compare. It also passes that address bit into physical bit 17+i in place of the physical base bit. Physical bits 16:0 always equal address bits 16:0. A mask of 0 gives a 128 KB block; a mask of 0x7FF gives a 256 MB block.
- R4: A descriptor can only match when its valid bit for the request's privilege is set. `lk_user`=1 selects the user-valid bit; `lk_user`=0 selects the supervisor-valid bit.
- R5: If several descriptors match, the lowest-numbered one supplies the address and protection, and its index is driven on `out_entry`.
- R6: On a descriptor match, `out_bat_hit` and `out_hit` are 1 and any page TLB hit is overridden. With no descriptor match, `out_hit` equals `tlb_hit` and `out_pa` equals `tlb_pa` when `tlb_hit` is 1. In that case `out_prot` and `out_entry` are 0.
- R7: On a descriptor match, `out_prot` carries that descriptor's protection code unchanged. The codes are: 00 no access, x1 read-only, 10 read/write.
- R8: The result of a request made with `lk_valid` high appears one clock later, with `out_valid` high. A cycle without the strobe yields all-zero outputs one clock later.
- R9: A lookup in the same cycle as a write sees the descriptor contents from before the write. The next lookup sees the new contents.
- R10: Reset clears every descriptor, so nothing can match, and drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor word write strobe |
| wr_idx | input | 2 | Descriptor index to write |
| wr_hi | input | 1 | 1 selects the compare word, 0 the translate word |
| wr_data | input | 32 | Word to store |
| lk_valid | input | 1 | Lookup request strobe |
| lk_ea | input | 32 | Effective address to translate |
| lk_user | input | 1 | Request privilege, 1 = user |
| tlb_hit | input | 1 | Page TLB hit for this request |
| tlb_pa | input | 32 | Page TLB physical address |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_hit | output | 1 | Any translation found |
| out_bat_hit | output | 1 | A block descriptor supplied the translation |
| out_entry | output | 2 | Index of the winning descriptor |
| out_pa | output | 32 | Physical address |
| out_prot | output | 2 | Protection code of the winning descriptor |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that every input, including `lk_ea` and `tlb_pa`, is stable around the rising edge, because the result checks compare the outputs against the inputs of the previous cycle. The bench drives all inputs on the falling edge and holds reset for several cycles. It generates lookup addresses near the programmed bases, so that matches, overlaps and near-misses all occur. It also issues writes in the same cycles as lookups to exercise the ordering between updates and lookups.

// File: rtl/bat_pkg.sv
package bat_pkg;
    parameter int unsigned AW      = 32;
    parameter int unsigned BLK_LSB = 17;
    parameter int unsigned MASK_W  = 11;
    parameter int unsigned PROT_W  = 2;

    localparam int unsigned TOP_LSB = BLK_LSB + MASK_W;
    localparam int unsigned BASE_W  = AW - BLK_LSB;
    localparam int unsigned MASK_LO = 2;

    typedef logic [PROT_W-1:0] prot_t;
    typedef logic [AW-1:0]     addr_t;

    typedef struct packed {
        logic [BASE_W-1:0] eff_base;
        logic [MASK_W-1:0] mask;
        logic              sup_ok;
        logic              usr_ok;
    } ent_hi_t;

    typedef struct packed {
        logic [BASE_W-1:0] phys_base;
        prot_t             prot;
    } ent_lo_t;
endpackage

// File: rtl/bat_entry_regs.sv
module bat_entry_regs
    import bat_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic                    wr_hi,
    input  addr_t                   wr_data,
    output ent_hi_t [N_ENT-1:0]     hi_o,
    output ent_lo_t [N_ENT-1:0]     lo_o
);
    typedef struct packed {
        ent_hi_t [N_ENT-1:0] hi;
        ent_lo_t [N_ENT-1:0] lo;
    } store_t;

    store_t  st_d, st_q;
    ent_hi_t hi_word;
    ent_lo_t lo_word;
    logic    unused_bits;

    // Field slicing of the incoming word; unused holes are dropped here.
    assign hi_word.eff_base  = wr_data[AW-1:BLK_LSB];
    assign hi_word.mask      = wr_data[MASK_LO+MASK_W-1:MASK_LO];
    assign hi_word.sup_ok    = wr_data[1];
    assign hi_word.usr_ok    = wr_data[0];
    assign lo_word.phys_base = wr_data[AW-1:BLK_LSB];
    assign lo_word.prot      = wr_data[PROT_W-1:0];
    assign unused_bits       = ^wr_data[BLK_LSB-1:MASK_LO+MASK_W];

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_hi) st_d.hi[i] = hi_word;
                else       st_d.lo[i] = lo_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi_o = st_q.hi;
    assign lo_o = st_q.lo;

    // R1: descriptors never change without a write strobe
    a_r1_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_chk
            // R1: a write to another descriptor leaves this one alone
            a_r1_other_untouched: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_idx != IDX_W'(g)) |=> $stable(st_q.hi[g]) && $stable(st_q.lo[g]));
            // R1: loading one word keeps the other word
            a_r1_word_split: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_hi) |=> $stable(st_q.lo[g]));
        end
    endgenerate
endmodule

// File: rtl/bat_match.sv
module bat_match
    import bat_pkg::*;
(
    input  addr_t   ea,
    input  logic    user,
    input  ent_hi_t hi,
    input  ent_lo_t lo,
    output logic    hit,
    output addr_t   pa
);
    logic              top_eq;
    logic              mid_eq;
    logic              priv_ok;
    logic [MASK_W-1:0] mid_diff;
    logic [MASK_W-1:0] mid_pa;

    always_comb begin
        top_eq   = (ea[AW-1:TOP_LSB] == hi.eff_base[BASE_W-1:MASK_W]);
        mid_diff = (ea[TOP_LSB-1:BLK_LSB] ^ hi.eff_base[MASK_W-1:0]) & ~hi.mask;
        mid_eq   = (mid_diff == '0);
        priv_ok  = user ? hi.usr_ok : hi.sup_ok;
        hit      = top_eq && mid_eq && priv_ok;
        mid_pa   = (lo.phys_base[MASK_W-1:0] & ~hi.mask) |
                   (ea[TOP_LSB-1:BLK_LSB] & hi.mask);
        pa       = {lo.phys_base[BASE_W-1:MASK_W], mid_pa, ea[BLK_LSB-1:0]};
    end
endmodule

// File: rtl/bat_pick.sv
module bat_pick
    import bat_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]   hits,
    input  addr_t [N_ENT-1:0]  pas,
    input  ent_lo_t [N_ENT-1:0] los,
    output logic               bat_hit,
    output logic [IDX_W-1:0]   idx,
    output logic [N_ENT-1:0]   grant,
    output addr_t              pa,
    output prot_t              prot
);
    always_comb begin
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
        bat_hit = |hits;
        grant   = hits & (~hits + N_ENT'(1));
        pa      = '0;
        prot    = '0;
        if (bat_hit) begin
            pa   = pas[idx];
            prot = los[idx].prot;
        end
    end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
    import bat_pkg::*;
#(
    parameter int unsigned N_ENT = 4,
    localparam int unsigned IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [31:0]       wr_data,
    input  logic              lk_valid,
    input  logic [31:0]       lk_ea,
    input  logic              lk_user,
    input  logic              tlb_hit,
    input  logic [31:0]       tlb_pa,
    output logic              out_valid,
    output logic              out_hit,
    output logic              out_bat_hit,
    output logic [IDX_W-1:0]  out_entry,
    output logic [31:0]       out_pa,
    output logic [1:0]        out_prot
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic             bat_hit;
        logic [IDX_W-1:0] entry;
        addr_t            pa;
        prot_t            prot;
    } rsp_t;

    ent_hi_t [N_ENT-1:0] ent_hi;
    ent_lo_t [N_ENT-1:0] ent_lo;
    logic    [N_ENT-1:0] ent_hit;
    addr_t   [N_ENT-1:0] ent_pa;
    logic                sel_hit;
    logic [IDX_W-1:0]    sel_idx;
    logic [N_ENT-1:0]    sel_grant;
    addr_t               sel_pa;
    prot_t               sel_prot;
    rsp_t                rsp_d, rsp_q;

    bat_entry_regs #(.N_ENT(N_ENT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .hi_o    (ent_hi),
        .lo_o    (ent_lo)
    );

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
            bat_match u_match (
                .ea   (lk_ea),
                .user (lk_user),
                .hi   (ent_hi[g]),
                .lo   (ent_lo[g]),
                .hit  (ent_hit[g]),
                .pa   (ent_pa[g])
            );
        end
    endgenerate

    bat_pick #(.N_ENT(N_ENT)) u_pick (
        .hits    (ent_hit),
        .pas     (ent_pa),
        .los     (ent_lo),
        .bat_hit (sel_hit),
        .idx     (sel_idx),
        .grant   (sel_grant),
        .pa      (sel_pa),
        .prot    (sel_prot)
    );

    // R5: the chosen index is the single lowest requester
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |-> (sel_grant == (N_ENT'(1) << sel_idx)) && $onehot0(sel_grant));

    always_comb begin
        rsp_d = '0;
        if (lk_valid) begin
            rsp_d.valid   = 1'b1;
            rsp_d.bat_hit = sel_hit;
            rsp_d.hit     = sel_hit || tlb_hit;
            if (sel_hit) begin
                rsp_d.entry = sel_idx;
                rsp_d.pa    = sel_pa;
                rsp_d.prot  = sel_prot;
            end else if (tlb_hit) begin
                rsp_d.pa    = tlb_pa;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign out_valid   = rsp_q.valid;
    assign out_hit     = rsp_q.hit;
    assign out_bat_hit = rsp_q.bat_hit;
    assign out_entry   = rsp_q.entry;
    assign out_pa      = rsp_q.pa;
    assign out_prot    = rsp_q.prot;

    // R8: result valid exactly one clock after the strobe
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(lk_valid)));
    // R8: idle slot yields zero outputs
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_hit && !out_bat_hit && out_pa == '0 && out_prot == '0);
    // R6: a block hit is always a hit
    a_r6_bat_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
        out_bat_hit |-> out_hit && out_valid);
    // R6: without a block hit the page result passes through
    a_r6_tlb_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && !out_bat_hit) |->
            out_hit == $past(tlb_hit) && out_prot == '0 && out_entry == '0);
    // R3: page offset bits pass straight through on a block hit
    a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_bat_hit) |-> out_pa[BLK_LSB-1:0] == $past(lk_ea[BLK_LSB-1:0]));
endmodule

// File: tb/tb_bat_xlate.sv
`timescale 1ns/1ps
module tb_bat_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic        wr_hi = 1'b0;
    logic [31:0] wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_user = 1'b0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_pa = '0;
    logic        out_valid, out_hit, out_bat_hit;
    logic [1:0]  out_entry, out_prot;
    logic [31:0] out_pa;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [31:0] m_hi [4];
    logic [31:0] m_lo [4];

    always #4 clk = ~clk;

    bat_xlate dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi),
        .wr_data(wr_data), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_user(lk_user),
        .tlb_hit(tlb_hit), .tlb_pa(tlb_pa), .out_valid(out_valid), .out_hit(out_hit),
        .out_bat_hit(out_bat_hit), .out_entry(out_entry), .out_pa(out_pa), .out_prot(out_prot)
    );

    function automatic logic [31:0] mk_hi(logic [31:0] base, logic [10:0] msk, bit sv, bit uv);
        return (base & 32'hFFFE_0000) | (32'(msk) << 2) | (32'(sv) << 1) | 32'(uv);
    endfunction

    function automatic logic [31:0] mk_lo(logic [31:0] base, logic [1:0] pr);
        return (base & 32'hFFFE_0000) | 32'(pr);
    endfunction

    // expected output packed as {valid, hit, bat, entry, pa, prot}
    function automatic logic [38:0] model(bit lv, logic [31:0] ea, bit usr, bit th, logic [31:0] tpa);
        bit found = 0;
        int win = 0;
        logic [31:0] pa = 0;
        logic [1:0]  pr = 0;
        if (!lv) return '0;
        for (int e = 0; e < 4; e++) begin
            logic [10:0] msk = m_hi[e][12:2];
            logic [31:0] cmpm = {4'hF, ~msk, 17'h0};
            logic [31:0] pasm = {4'h0, msk, 17'h1FFFF};
            bit ok = usr ? m_hi[e][0] : m_hi[e][1];
            if (!found && ok && (((ea ^ m_hi[e]) & cmpm) == 0)) begin
                found = 1;
                win   = e;
                pa    = ((m_lo[e] & 32'hFFFE_0000) & ~pasm) | (ea & pasm);
                pr    = m_lo[e][1:0];
            end
        end
        if (!found && th) pa = tpa;
        return {1'b1, found | th, found, 2'(win), pa, pr};
    endfunction

    task automatic compare(string tag, logic [38:0] exp);
        logic [38:0] act = {out_valid, out_hit, out_bat_hit, out_entry, out_pa, out_prot};
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got v=%0b h=%0b b=%0b e=%0d pa=%08h pr=%0b, expected v=%0b h=%0b b=%0b e=%0d pa=%08h pr=%0b",
                     tag, act[38], act[37], act[36], act[35:34], act[33:2], act[1:0],
                     exp[38], exp[37], exp[36], exp[35:34], exp[33:2], exp[1:0]);
        end
    endtask

    task automatic step(string tag, bit we, logic [1:0] wi, bit wh, logic [31:0] wd,
                        bit lv, logic [31:0] ea, bit usr, bit th, logic [31:0] tpa);
        logic [38:0] exp;
        wr_en = we; wr_idx = wi; wr_hi = wh; wr_data = wd;
        lk_valid = lv; lk_ea = ea; lk_user = usr; tlb_hit = th; tlb_pa = tpa;
        exp = model(lv, ea, usr, th, tpa);
        if (we) begin
            if (wh) m_hi[wi] = wd; else m_lo[wi] = wd;
        end
        @(negedge clk);
        compare(tag, exp);
    endtask

    task automatic wr(logic [1:0] i, bit h, logic [31:0] d);
        step("R1 write", 1, i, h, d, 0, 0, 0, 0, 0);
    endtask

    task automatic look(string tag, logic [31:0] ea, bit usr, bit th = 0, logic [31:0] tpa = 0);
        step(tag, 0, 0, 0, 0, 1, ea, usr, th, tpa);
    endtask

    initial begin
        for (int e = 0; e < 4; e++) begin m_hi[e] = 0; m_lo[e] = 0; end
        repeat (3) @(negedge clk);
        compare("R10 reset outputs", '0);
        rst_n = 1'b1;
        look("R10 cleared array misses", 32'h0000_0000, 0);
        look("R10 cleared array misses user", 32'h0000_0000, 1);

        // descriptor 0: 128 KB supervisor-only read/write
        wr(0, 1, mk_hi(32'h1000_0000, 11'h000, 1, 0));
        wr(0, 0, mk_lo(32'h8002_0000, 2'b10));
        look("R2 supervisor hit", 32'h1001_2345, 0);
        look("R4 user blocked", 32'h1001_2345, 1);
        look("R3 outside 128K block", 32'h1002_0000, 0);
        look("R2 top nibble differs", 32'h3001_2345, 0);

        // descriptor 1: 256 MB both privileges read-only
        wr(1, 1, mk_hi(32'h2000_0000, 11'h7FF, 1, 1));
        wr(1, 0, mk_lo(32'hA000_0000, 2'b01));
        look("R3 256M block pass bits", 32'h2ABC_DEF0, 1);
        look("R7 read-only code", 32'h2FFF_FFFF, 0);

        // descriptor 2 overlaps descriptor 1
        wr(2, 1, mk_hi(32'h2000_0000, 11'h000, 1, 1));
        wr(2, 0, mk_lo(32'hC000_0000, 2'b11));
        look("R5 lowest index wins", 32'h2000_1000, 0);
        wr(1, 1, mk_hi(32'h2000_0000, 11'h7FF, 0, 0));
        look("R5 next entry when lower invalid", 32'h2000_1000, 0);
        look("R1 lower word kept on upper write", 32'h2100_0000, 0);

        // page TLB interplay
        look("R6 block overrides page", 32'h2000_1000, 0, 1, 32'h1234_5678);
        look("R6 page fallback", 32'h5000_0000, 0, 1, 32'h1234_5678);
        look("R6 total miss", 32'h5000_0000, 0, 0, 32'h1234_5678);
        step("R8 idle slot zero", 0, 0, 0, 0, 0, 32'h2000_1000, 0, 1, 32'hFFFF_FFFF);

        // same-cycle write and lookup
        wr(3, 0, mk_lo(32'h6000_0000, 2'b00));
        step("R9 old contents same cycle", 1, 3, 1, mk_hi(32'h5000_0000, 11'h00F, 1, 1),
             1, 32'h5004_0000, 0, 0, 0);
        look("R9 new contents next cycle", 32'h5004_0000, 0);
        look("R7 no-access code", 32'h5007_FFFF, 1);
        wr(3, 0, mk_lo(32'h7FFE_0000, 2'b10));
        look("R1 translate word rewrite", 32'h5006_0004, 1);
        wr(0, 1, mk_hi(32'h0000_0000, 11'h155, 1, 1));
        look("R3 sparse mask", 32'h0AAA_1111, 0);
        look("R3 sparse mask near miss", 32'h0001_1111 | 32'h0002_0000 << 1, 0);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            bit we = ($urandom_range(7) == 0);
            logic [1:0] wi = 2'($urandom_range(3));
            bit wh = $urandom_range(1);
            logic [31:0] wd = $urandom;
            int pick = $urandom_range(3);
            logic [31:0] ea = (m_hi[pick] & 32'hFFFE_0000) ^ ($urandom & 32'h0F01_FFFF & {32{$urandom_range(1) == 1'b1}})
                              ^ ($urandom & 32'h0001_FFFF);
            if (we && wh) wd[1:0] = 2'b11;
            step("R2 random mix", we, wi, wh, wd, $urandom_range(4) != 0, ea,
                 $urandom_range(1), $urandom_range(1), $urandom);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule